// File: doc/BRIEF.md
# Downlink Gold Scrambling Code Generator

This block produces the in-phase and quadrature chip streams of a downlink Gold scrambling code. Two 18-stage linear feedback shift registers run side by side. The first uses the feedback x^18+x^7+1 and the second uses x^18+x^10+x^7+x^5+1. The chip on each rail is an XOR of a fixed set of stages from both registers.

A load request captures an 18-bit code number n and seeds both registers. The block then clocks only the first register forward n times. During that advance it raises `busy` and gives no valid chips. After the advance it emits one I/Q chip pair on every clock where `chip_en` is high. A chip counter marks the first chip of each radio frame. When the last chip of a frame has gone out, the block seeds the registers again and repeats the n-step advance with the stored code number.

The frame length and the register polynomials are parameters. The defaults give a 38400-chip frame.

Top module: `dlsc_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `busy`, `chip_valid` and `frame_start` are low.
- R2: A load with `code_num` = 0 seeds register 1 with only stage 0 set and register 2 with all ones. On the next cycle, with `chip_en` high, the block therefore emits `chip_i` = 0 and `chip_q` = 0.
- R3: A load with `code_num` = n > 0 makes `busy` high for exactly n cycles, starting on the cycle after the load. `chip_valid` is low while `busy` is high.
- R4: `chip_i` equals stage 0 of register 1 XOR stage 0 of register 2.
- R5: `chip_q` is the XOR of stages 4, 6 and 15 of register 1 and stages 5, 6, 8, 9, 10, 11, 12, 13, 14 and 15 of register 2.
- R6: Each register shifts toward stage 0, and the new bit enters stage 17. The new bit of register 1 is stage 0 XOR stage 7. The new bit of register 2 is the XOR of stages 0, 5, 7 and 10. During the advance only register 1 steps. In the run phase both registers step on each chip with `chip_en` high.
- R7: `chip_valid` is high only in the run phase and only while `chip_en` is high. With `chip_en` low, neither register moves and the chip outputs hold their values.
- R8: `frame_start` is high with the first valid chip of each frame. After FRAME_CHIPS valid chips the block seeds the registers again and repeats the advance.
- R9: The code number is sampled only at a load. Changes on `code_num` at other times have no effect, including on the advance that follows a frame wrap.
- R10: A load during the advance or the run phase restarts the generator at once, with the new code number.
- R11: With `code_num` = 0, at a load or at a frame wrap, `busy` stays low and valid chips continue on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Pulse that seeds the registers and samples `code_num` |
| code_num | input | 18 | Scrambling code number n |
| chip_en | input | 1 | Request one chip pair this cycle |
| busy | output | 1 | High during the n-step advance |
| chip_valid | output | 1 | Chip outputs are valid this cycle |
| chip_i | output | 1 | In-phase chip |
| chip_q | output | 1 | Quadrature chip |
| frame_start | output | 1 | Marks the first chip of a frame |

## Verification
The bench builds the block with FRAME_CHIPS set to 40, so every run passes through many frame wraps. This exercises the re-seed, repeated advances after a wrap, and a code-number change between wraps. The code width and the polynomials keep their default values, so the chips are compared against the true 18-stage sequences. Code numbers of 0, a few, and several hundred are used. Together these cover the skipped advance, short advances and long advances, within the cycle budget.

// File: rtl/dlsc_pkg.sv
package dlsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADV  = 2'd1,
      ST_RUN  = 2'd2
   } dlsc_state_e;

   function automatic bit mask_has_lsb(input logic [31:0] m);
      return m[0];
   endfunction
endpackage

// File: rtl/dlsc_lfsr.sv
module dlsc_lfsr #(
   parameter int          WIDTH    = 18,
   parameter logic [31:0] TAP_MASK = 32'h0000_0081,
   parameter logic [31:0] SEED     = 32'h0000_0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] state_o
);
   localparam logic [WIDTH-1:0] TAPS = TAP_MASK[WIDTH-1:0];
   localparam logic [WIDTH-1:0] INIT = SEED[WIDTH-1:0];

   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("dlsc_lfsr: WIDTH must lie in 2..32");
      end
      if (!dlsc_pkg::mask_has_lsb(TAP_MASK)) begin : g_bad_taps
         $error("dlsc_lfsr: feedback mask must include stage 0");
      end
      if (INIT == '0) begin : g_bad_seed
         $error("dlsc_lfsr: all-zero seed locks the register");
      end
   endgenerate

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] q_next;
   logic             fb;

   assign fb = ^(q & TAPS);

   generate
      for (genvar b = 0; b < WIDTH - 1; b++) begin : g_shift
         assign q_next[b] = q[b+1];
      end
   endgenerate
   assign q_next[WIDTH-1] = fb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= INIT;
      end else if (seed_i) begin
         q <= INIT;
      end else if (step_i) begin
         q <= q_next;
      end
   end

   assign state_o = q;
endmodule

// File: rtl/dlsc_chip_cnt.sv
module dlsc_chip_cnt #(
   parameter int FRAME_CHIPS = 38400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic first_o,
   output logic last_o
);
   localparam int CW = (FRAME_CHIPS > 1) ? $clog2(FRAME_CHIPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(FRAME_CHIPS - 1);

   generate
      if (FRAME_CHIPS < 2) begin : g_bad_frame
         $error("dlsc_chip_cnt: FRAME_CHIPS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (inc_i) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign first_o = (cnt == '0);
   assign last_o  = (cnt == LAST);
endmodule

// File: rtl/dlsc_seq.sv
module dlsc_seq
   import dlsc_pkg::*;
#(
   parameter int CODE_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              chip_en_i,
   input  logic              frame_last_i,
   output logic              seed_o,
   output logic              adv_step_o,
   output logic              run_step_o,
   output logic              cnt_clr_o,
   output logic              busy_o,
   output logic              run_o
);
   generate
      if (CODE_W < 1 || CODE_W > 31) begin : g_bad_code
         $error("dlsc_seq: CODE_W must lie in 1..31");
      end
   endgenerate

   dlsc_state_e       st;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] left_q;
   logic              wrap;

   assign wrap       = (st == ST_RUN) && chip_en_i && frame_last_i && !load_i;
   assign seed_o     = load_i || wrap;
   assign adv_step_o = (st == ST_ADV) && !load_i;
   assign run_step_o = (st == ST_RUN) && chip_en_i && !load_i;
   assign cnt_clr_o  = load_i || (st != ST_RUN);
   assign busy_o     = (st == ST_ADV);
   assign run_o      = (st == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         code_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         code_q <= code_i;
         left_q <= code_i;
         st     <= (code_i == '0) ? ST_RUN : ST_ADV;
      end else begin
         unique case (st)
            ST_ADV: begin
               left_q <= left_q - 1'b1;
               if (left_q == CODE_W'(1)) begin
                  st <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (wrap) begin
                  left_q <= code_q;
                  st     <= (code_q == '0) ? ST_RUN : ST_ADV;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dlsc_combine.sv
module dlsc_combine #(
   parameter int          WIDTH   = 18,
   parameter logic [31:0] Q1_MASK = 32'h0000_8050,
   parameter logic [31:0] Q2_MASK = 32'h0000_FF60
) (
   input  logic [WIDTH-1:0] r1_i,
   input  logic [WIDTH-1:0] r2_i,
   output logic             i_o,
   output logic             q_o
);
   localparam logic [WIDTH-1:0] M1 = Q1_MASK[WIDTH-1:0];
   localparam logic [WIDTH-1:0] M2 = Q2_MASK[WIDTH-1:0];

   generate
      if (M1 == '0 && M2 == '0) begin : g_bad_q
         $error("dlsc_combine: quadrature masks are both empty");
      end
   endgenerate

   assign i_o = r1_i[0] ^ r2_i[0];
   assign q_o = (^(r1_i & M1)) ^ (^(r2_i & M2));
endmodule

// File: rtl/dlsc_gen.sv
module dlsc_gen #(
   parameter int          REG_W       = 18,
   parameter int          CODE_W      = 18,
   parameter int          FRAME_CHIPS = 38400,
   parameter logic [31:0] R1_TAPS     = 32'h0000_0081,
   parameter logic [31:0] R2_TAPS     = 32'h0000_04A1,
   parameter logic [31:0] Q1_MASK     = 32'h0000_8050,
   parameter logic [31:0] Q2_MASK     = 32'h0000_FF60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code_num,
   input  logic              chip_en,
   output logic              busy,
   output logic              chip_valid,
   output logic              chip_i,
   output logic              chip_q,
   output logic              frame_start
);
   localparam logic [31:0] R1_SEED = 32'h0000_0001;
   localparam logic [31:0] R2_SEED = (REG_W >= 32) ? 32'hFFFF_FFFF : ((32'h1 << REG_W) - 32'h1);

   logic             seed, adv_step, run_step, cnt_clr, run;
   logic             f_first, f_last;
   logic [REG_W-1:0] r1, r2;

   dlsc_seq #(.CODE_W(CODE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(code_num),
      .chip_en_i(chip_en), .frame_last_i(f_last), .seed_o(seed),
      .adv_step_o(adv_step), .run_step_o(run_step), .cnt_clr_o(cnt_clr),
      .busy_o(busy), .run_o(run)
   );

   dlsc_lfsr #(.WIDTH(REG_W), .TAP_MASK(R1_TAPS), .SEED(R1_SEED)) u_r1 (
      .clk(clk), .rst_n(rst_n), .seed_i(seed),
      .step_i(adv_step | run_step), .state_o(r1)
   );

   dlsc_lfsr #(.WIDTH(REG_W), .TAP_MASK(R2_TAPS), .SEED(R2_SEED)) u_r2 (
      .clk(clk), .rst_n(rst_n), .seed_i(seed),
      .step_i(run_step), .state_o(r2)
   );

   dlsc_chip_cnt #(.FRAME_CHIPS(FRAME_CHIPS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(run_step),
      .first_o(f_first), .last_o(f_last)
   );

   dlsc_combine #(.WIDTH(REG_W), .Q1_MASK(Q1_MASK), .Q2_MASK(Q2_MASK)) u_comb (
      .r1_i(r1), .r2_i(r2), .i_o(chip_i), .q_o(chip_q)
   );

   assign chip_valid  = run && chip_en;
   assign frame_start = chip_valid && f_first;
endmodule

// File: rtl/dlsc_gen_chk.sv
module dlsc_gen_chk #(
   parameter int CODE_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load,
   input logic [CODE_W-1:0] code_num,
   input logic              chip_en,
   input logic              busy,
   input logic              chip_valid,
   input logic              chip_i,
   input logic              chip_q,
   input logic              frame_start
);
   AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !chip_valid); // R3

   AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_num != '0) |=> busy); // R3

   AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_num == '0) |=> !busy); // R11

   AST_SEED_CHIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_num == '0) |=> (!chip_i && !chip_q)); // R2

   AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      chip_valid |-> chip_en); // R7

   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en && !load && !busy) |=> ($stable(chip_i) && $stable(chip_q))); // R7

   AST_FS_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> chip_valid); // R8
endmodule

bind dlsc_gen dlsc_gen_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .load(load), .code_num(code_num),
   .chip_en(chip_en), .busy(busy), .chip_valid(chip_valid),
   .chip_i(chip_i), .chip_q(chip_q), .frame_start(frame_start)
);

// File: tb/dlsc_gen_test.sv
`timescale 1ns/1ps
module dlsc_gen_test;
   localparam int FR = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [17:0] code_num = '0;
   logic        chip_en = 1'b0;
   logic        busy, chip_valid, chip_i, chip_q, frame_start;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   dlsc_gen #(.FRAME_CHIPS(FR)) uut (
      .clk(clk), .rst_n(rst_n), .load(load), .code_num(code_num),
      .chip_en(chip_en), .busy(busy), .chip_valid(chip_valid),
      .chip_i(chip_i), .chip_q(chip_q), .frame_start(frame_start)
   );

   // Behavioural model: the two m-sequences held as bit queues, index k = stage k.
   int m_q1[$];
   int m_q2[$];
   int m_phase = 0;      // 0 idle, 1 advancing, 2 running
   int m_left = 0;
   int m_code = 0;
   int m_chips = 0;

   function automatic void m_seed();
      m_q1 = {};
      m_q2 = {};
      for (int k = 0; k < 18; k++) begin
         m_q1.push_back(k == 0 ? 1 : 0);
         m_q2.push_back(1);
      end
   endfunction

   function automatic void m_step1();
      int nb;
      nb = m_q1[0] ^ m_q1[7];
      void'(m_q1.pop_front());
      m_q1.push_back(nb);
   endfunction

   function automatic void m_step2();
      int nb;
      nb = m_q2[0] ^ m_q2[5] ^ m_q2[7] ^ m_q2[10];
      void'(m_q2.pop_front());
      m_q2.push_back(nb);
   endfunction

   function automatic int m_i();
      return m_q1[0] ^ m_q2[0];
   endfunction

   function automatic int m_q();
      int v;
      v = m_q1[4] ^ m_q1[6] ^ m_q1[15];
      v = v ^ m_q2[5] ^ m_q2[6];
      for (int k = 8; k <= 15; k++) v = v ^ m_q2[k];
      return v;
   endfunction

   initial m_seed();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0;
         m_seed();
         m_chips = 0;
      end else if (load) begin
         m_seed();
         m_code = int'(code_num);
         m_left = m_code;
         m_chips = 0;
         m_phase = (m_code == 0) ? 2 : 1;
      end else if (m_phase == 1) begin
         m_step1();
         m_left--;
         if (m_left == 0) m_phase = 2;
      end else if (m_phase == 2 && chip_en) begin
         if (m_chips == FR - 1) begin
            m_seed();
            m_chips = 0;
            m_left = m_code;
            m_phase = (m_code == 0) ? 2 : 1;
         end else begin
            m_step1();
            m_step2();
            m_chips++;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   task automatic compare();
      int mv;
      mv = (m_phase == 2 && chip_en) ? 1 : 0;
      chk("R3 busy", int'(busy), (m_phase == 1) ? 1 : 0);
      chk("R7 chip_valid", int'(chip_valid), mv);
      if (mv == 1) begin
         chk("R4/R6 chip_i", int'(chip_i), m_i());
         chk("R5/R6 chip_q", int'(chip_q), m_q());
         chk("R8 frame_start", int'(frame_start), (m_chips == 0) ? 1 : 0);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
      compare();
   endtask

   int busy_cnt;
   int hold_i, hold_q;

   initial begin
      // R1: reset state
      #1;
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 valid in reset", int'(chip_valid), 0);
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      cyc();
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 valid after reset", int'(chip_valid), 0);
      chk("R1 frame_start after reset", int'(frame_start), 0);

      // R2 / R11: load with code 0
      code_num = 18'd0;
      load = 1'b1;
      chip_en = 1'b1;
      cyc();
      load = 1'b0;
      chk("R11 no busy for code 0", int'(busy), 0);
      chk("R2 first chip_i", int'(chip_i), 0);
      chk("R2 first chip_q", int'(chip_q), 0);
      chk("R8 first frame_start", int'(frame_start), 1);
      repeat (3 * FR + 5) cyc();

      // R7: chip_en low holds the sequence
      chip_en = 1'b0;
      cyc();
      hold_i = int'(chip_i);
      hold_q = int'(chip_q);
      repeat (4) cyc();
      chk("R7 chip_i held", int'(chip_i), hold_i);
      chk("R7 chip_q held", int'(chip_q), hold_q);
      chk("R7 no valid when disabled", int'(chip_valid), 0);
      for (int k = 0; k < 150; k++) begin
         chip_en = ((k % 3) != 1);
         cyc();
      end

      // R3 / R9: short advance, then code_num changes without a load
      chip_en = 1'b1;
      code_num = 18'd5;
      load = 1'b1;
      cyc();
      load = 1'b0;
      code_num = 18'd77;
      busy_cnt = 0;
      while (busy && busy_cnt < 1000) begin
         busy_cnt++;
         cyc();
      end
      chk("R3 busy length n=5", busy_cnt, 5);
      for (int k = 0; k < FR - 1; k++) cyc();
      busy_cnt = 0;
      while (!busy && busy_cnt < 10) begin
         busy_cnt++;
         cyc();
      end
      busy_cnt = 0;
      while (busy && busy_cnt < 1000) begin
         busy_cnt++;
         cyc();
      end
      chk("R9 wrap advance uses stored n=5", busy_cnt, 5);
      for (int k = 0; k < 3 * FR; k++) begin
         chip_en = ((k % 5) != 2);
         cyc();
      end

      // R10: long advance interrupted by a new load, then a load in the run phase
      chip_en = 1'b1;
      code_num = 18'd300;
      load = 1'b1;
      cyc();
      load = 1'b0;
      repeat (40) cyc();
      code_num = 18'd3;
      load = 1'b1;
      cyc();
      load = 1'b0;
      busy_cnt = 0;
      while (busy && busy_cnt < 1000) begin
         busy_cnt++;
         cyc();
      end
      chk("R10 restart during advance n=3", busy_cnt, 3);
      repeat (FR + 7) cyc();
      code_num = 18'd300;
      load = 1'b1;
      cyc();
      load = 1'b0;
      busy_cnt = 0;
      while (busy && busy_cnt < 1000) begin
         busy_cnt++;
         cyc();
      end
      chk("R10 restart during run n=300", busy_cnt, 300);
      repeat (2 * FR + 3) cyc();

      // R11: code 0 across a wrap keeps busy low
      code_num = 18'd0;
      load = 1'b1;
      cyc();
      load = 1'b0;
      busy_cnt = 0;
      for (int k = 0; k < 2 * FR + 2; k++) begin
         cyc();
         if (busy) busy_cnt++;
      end
      chk("R11 busy never high for code 0", busy_cnt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule